// File: doc/BRIEF.md
# Event-Based Branch Dispatch Unit

This block decides when a latched performance monitor alert turns into a branch to a user-level event handler. It holds three 64-bit registers: the handler address, the return address and a branch status/control word. A request is latched on `pmIrq` and waits in a pending flag. The branch is delivered on a clock edge where all of these hold: a request is pending, the core is in user (problem) state, the event-branch facility is enabled, the monitor's event-based enable is set, and the global-enable and monitor-event-enable bits of the status word are both set.

Taking the branch is one atomic step. The global-enable bit is cleared, the monitor-event-occurred bit is set, the current next-instruction address is saved as the return address, and a one-cycle redirect strobe is raised with the handler address as its target. The block keeps no machine state register and changes none. A re-arm pulse models the return-from-handler instruction. It sets global-enable again and redirects to the saved return address. A simple write port lets the surrounding core load the three registers.

Top module: `ebb_dispatch`

## Requirements
- R1: After reset, all three registers are zero, no request is pending, `redirect` is 0 and `redirectAddr` is zero.
- R2: When `wrEn` is high, `wrSel` selects the register to write: 0 = handler, 1 = return, 2 = status, 3 = none. The write lands at the next edge. The handler register stores the data with bits [1:0] forced to zero.
- R3: A high `pmIrq` at an edge sets the pending flag. The flag then stays set until the branch is taken, for as long as delivery is blocked (for example while `userMode` is 0).
- R4: The branch is taken at an edge only if a request is pending and `userMode`, `facEn`, `mmcrEbe`, status bit 63 (global enable) and status bit 32 (monitor-event enable) are all 1, and `rearm` is 0. After that edge, `redirect` is 1.
- R5: At the take edge, status bit 63 is cleared and status bit 0 (event occurred) is set, while all other status bits are kept. The return register receives `curNia`, `redirectAddr` receives the handler register value, and the pending flag clears unless `pmIrq` is high at that same edge.
- R6: The redirect strobe of a take lasts exactly one cycle.
- R7: A high `rearm` at an edge sets status bit 63 and raises `redirect` for one cycle with `redirectAddr` equal to the return register. In the same cycle it blocks a take, which leaves the request pending.
- R8: A write requested in a cycle where a take or a re-arm happens is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pmIrq | input | 1 | Performance monitor alert request |
| userMode | input | 1 | 1 when the core is in problem (user) state |
| facEn | input | 1 | Event-branch facility enable |
| mmcrEbe | input | 1 | Monitor event-based enable |
| curNia | input | 64 | Current next-instruction address |
| rearm | input | 1 | Return-from-handler pulse |
| wrEn | input | 1 | Register write enable |
| wrSel | input | 2 | Register select for writes |
| wrData | input | 64 | Write data |
| redirect | output | 1 | One-cycle redirect strobe |
| redirectAddr | output | 64 | Redirect target |
| handlerAddr | output | 64 | Handler address register |
| returnAddr | output | 64 | Return address register |
| statusReg | output | 64 | Branch status/control register |
| pending | output | 1 | Latched, not yet delivered request |

## Verification
A wrong gate on the delivery condition shows at the next edge, as a `redirect` that fires or fails to fire for that input combination. A lost pending flag shows as a missing branch once the core leaves privileged state. A wrong update on the take edge shows at once in `statusReg`, `returnAddr` or `redirectAddr`. A later re-arm then brings the saved return point back out on `redirectAddr`. Discarded writes and the priority of re-arm over a take are visible in the register outputs one cycle after the colliding edge.

// File: rtl/ebb_pkg.sv
package ebb_pkg;
  localparam int ADDR_W   = 64;
  localparam int GE_BIT   = 63;
  localparam int PME_BIT  = 32;
  localparam int PMEO_BIT = 0;

  typedef enum logic [1:0] {
    SEL_HANDLER = 2'd0,
    SEL_RETURN  = 2'd1,
    SEL_STATUS  = 2'd2,
    SEL_NONE    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic take;
    logic rearm;
    logic wrHandler;
    logic wrReturn;
    logic wrStatus;
  } ctrlStrobe_t;
endpackage

// File: rtl/ebb_ctrl.sv
module ebb_ctrl
  import ebb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pmIrq,
  input  logic        userMode,
  input  logic        facEn,
  input  logic        mmcrEbe,
  input  logic        geBit,
  input  logic        pmeBit,
  input  logic        rearm,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  output ctrlStrobe_t strobe,
  output logic        pendingQ,
  output logic        redirectQ
);
  logic enablesOk;
  logic takeNow;
  logic wrAllowed;

  assign enablesOk = userMode & facEn & mmcrEbe & geBit & pmeBit;
  assign takeNow   = pendingQ & enablesOk & ~rearm;
  assign wrAllowed = wrEn & ~takeNow & ~rearm;

  always_comb begin
    strobe.take      = takeNow;
    strobe.rearm     = rearm;
    strobe.wrHandler = wrAllowed & (regSel_e'(wrSel) == SEL_HANDLER);
    strobe.wrReturn  = wrAllowed & (regSel_e'(wrSel) == SEL_RETURN);
    strobe.wrStatus  = wrAllowed & (regSel_e'(wrSel) == SEL_STATUS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ  <= 1'b0;
      redirectQ <= 1'b0;
    end else begin
      pendingQ  <= pmIrq | (pendingQ & ~takeNow);
      redirectQ <= takeNow | rearm;
    end
  end
endmodule

// File: rtl/ebb_regs.sv
module ebb_regs
  import ebb_pkg::*;
#(
  parameter int W = ADDR_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobe_t  strobe,
  input  logic [W-1:0] curNia,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] handlerQ,
  output logic [W-1:0] returnQ,
  output logic [W-1:0] statusQ,
  output logic [W-1:0] targetQ,
  output logic         geBit,
  output logic         pmeBit
);
  localparam int ALIGN_BITS = 2;

  assign geBit  = statusQ[GE_BIT];
  assign pmeBit = statusQ[PME_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      handlerQ <= '0;
      returnQ  <= '0;
      statusQ  <= '0;
      targetQ  <= '0;
    end else begin
      if (strobe.take) begin
        returnQ            <= curNia;
        targetQ            <= handlerQ;
        statusQ[GE_BIT]    <= 1'b0;
        statusQ[PMEO_BIT]  <= 1'b1;
      end else if (strobe.rearm) begin
        targetQ            <= returnQ;
        statusQ[GE_BIT]    <= 1'b1;
      end else begin
        if (strobe.wrHandler) handlerQ <= {wrData[W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        if (strobe.wrReturn)  returnQ  <= wrData;
        if (strobe.wrStatus)  statusQ  <= wrData;
      end
    end
  end
endmodule

// File: rtl/ebb_dispatch.sv
module ebb_dispatch
  import ebb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pmIrq,
  input  logic              userMode,
  input  logic              facEn,
  input  logic              mmcrEbe,
  input  logic [ADDR_W-1:0] curNia,
  input  logic              rearm,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic [ADDR_W-1:0] handlerAddr,
  output logic [ADDR_W-1:0] returnAddr,
  output logic [ADDR_W-1:0] statusReg,
  output logic              pending
);
  ctrlStrobe_t strobe;
  logic geBit;
  logic pmeBit;

  ebb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pmIrq(pmIrq), .userMode(userMode),
    .facEn(facEn), .mmcrEbe(mmcrEbe), .geBit(geBit), .pmeBit(pmeBit),
    .rearm(rearm), .wrEn(wrEn), .wrSel(wrSel), .strobe(strobe),
    .pendingQ(pending), .redirectQ(redirect)
  );

  ebb_regs #(.W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curNia(curNia),
    .wrData(wrData), .handlerQ(handlerAddr), .returnQ(returnAddr),
    .statusQ(statusReg), .targetQ(redirectAddr), .geBit(geBit),
    .pmeBit(pmeBit)
  );
endmodule

// File: rtl/ebb_dispatch_chk.sv
module ebb_dispatch_chk
  import ebb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              pmIrq,
  input logic              userMode,
  input logic              facEn,
  input logic              mmcrEbe,
  input logic [ADDR_W-1:0] curNia,
  input logic              rearm,
  input logic              redirect,
  input logic [ADDR_W-1:0] redirectAddr,
  input logic [ADDR_W-1:0] handlerAddr,
  input logic [ADDR_W-1:0] returnAddr,
  input logic [ADDR_W-1:0] statusReg,
  input logic              pending
);
  logic seenEdge;
  always_ff @(posedge clk) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  AST_HANDLER_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    handlerAddr[1:0] == 2'b00); // R2

  AST_PRIV_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !userMode) |=> pending); // R3

  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && redirect && !$past(rearm)) |->
      ($past(userMode) && $past(facEn) && $past(mmcrEbe) && $past(pending))); // R4

  AST_TAKE_EFFECTS: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && redirect && !$past(rearm)) |->
      (!statusReg[GE_BIT] && statusReg[PMEO_BIT] &&
       returnAddr == $past(curNia) && redirectAddr == $past(handlerAddr))); // R5

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && redirect && !$past(rearm) && !rearm) |=> !redirect); // R6

  AST_REARM_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    rearm |=> (redirect && statusReg[GE_BIT] && redirectAddr == $past(returnAddr))); // R7
endmodule

bind ebb_dispatch ebb_dispatch_chk u_chk (
  .clk(clk), .rstN(rstN), .pmIrq(pmIrq), .userMode(userMode), .facEn(facEn),
  .mmcrEbe(mmcrEbe), .curNia(curNia), .rearm(rearm), .redirect(redirect),
  .redirectAddr(redirectAddr), .handlerAddr(handlerAddr),
  .returnAddr(returnAddr), .statusReg(statusReg), .pending(pending)
);

// File: tb/ebb_dispatch_tb.sv
module ebb_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] HBASE = 64'hA5A5_0000_1234_0000;
  localparam logic [63:0] NBASE = 64'h0000_7000_0000_0000;

  logic clk = 1'b0;
  logic rstN, pmIrq, userMode, facEn, mmcrEbe, rearm, wrEn;
  logic [1:0] wrSel;
  logic [63:0] curNia, wrData;
  logic redirect, pending;
  logic [63:0] redirectAddr, handlerAddr, returnAddr, statusReg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ebb_dispatch u_dut (
    .clk(clk), .rstN(rstN), .pmIrq(pmIrq), .userMode(userMode), .facEn(facEn),
    .mmcrEbe(mmcrEbe), .curNia(curNia), .rearm(rearm), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .redirect(redirect),
    .redirectAddr(redirectAddr), .handlerAddr(handlerAddr),
    .returnAddr(returnAddr), .statusReg(statusReg), .pending(pending)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; pmIrq = 0; userMode = 0; facEn = 0; mmcrEbe = 0;
    rearm = 0; wrEn = 0; wrSel = 2'd3; wrData = '0; curNia = '0;
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [63:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    step();
    wrEn = 1'b0; wrSel = 2'd3;
  endtask

  function automatic logic [63:0] statusVal(input bit ge, input bit pme);
    logic [63:0] v;
    v = 64'h0000_00F0_0000_0F00;
    v[63] = ge; v[32] = pme;
    return v;
  endfunction

  initial begin
    logic [63:0] hExp, sExp;
    doReset();
    // R1 reset state
    check("R1 redirect", {63'd0, redirect}, 64'd0);
    check("R1 pending", {63'd0, pending}, 64'd0);
    check("R1 handler", handlerAddr, 64'd0);
    check("R1 return", returnAddr, 64'd0);
    check("R1 status", statusReg, 64'd0);
    check("R1 target", redirectAddr, 64'd0);

    // Sweep over all 64 combinations of the gating inputs
    for (int i = 0; i < 64; i++) begin
      bit u, f, m, g, p, q, exp;
      {u, f, m, g, p, q} = 6'(i);
      exp = u & f & m & g & p & q;
      doReset();
      writeReg(2'd0, HBASE | (64'(i) << 8) | 64'd3);
      hExp = (HBASE | (64'(i) << 8)) & ~64'd3;
      check("R2 handler aligned", handlerAddr, hExp);
      sExp = statusVal(g, p);
      writeReg(2'd2, sExp);
      check("R2 status write", statusReg, sExp);
      userMode = u; facEn = f; mmcrEbe = m; curNia = NBASE + 64'(i * 4);
      pmIrq = q;
      step();
      pmIrq = 1'b0;
      check("R3 pending latched", {63'd0, pending}, {63'd0, q});
      check("R4 no early redirect", {63'd0, redirect}, 64'd0);
      step();
      check("R4 delivery gate", {63'd0, redirect}, {63'd0, exp});
      if (exp) begin
        logic [63:0] sTaken;
        sTaken = sExp; sTaken[63] = 1'b0; sTaken[0] = 1'b1;
        check("R5 status update", statusReg, sTaken);
        check("R5 return saved", returnAddr, NBASE + 64'(i * 4));
        check("R5 target", redirectAddr, hExp);
        check("R5 pending cleared", {63'd0, pending}, 64'd0);
        curNia = 64'h1;
        step();
        check("R6 strobe one cycle", {63'd0, redirect}, 64'd0);
        rearm = 1'b1;
        step();
        rearm = 1'b0;
        check("R7 rearm redirect", {63'd0, redirect}, 64'd1);
        check("R7 rearm target", redirectAddr, NBASE + 64'(i * 4));
        check("R7 rearm ge", {63'd0, statusReg[63]}, 64'd1);
        step();
        check("R7 rearm strobe ends", {63'd0, redirect}, 64'd0);
      end else begin
        check("R3 request held", {63'd0, pending}, {63'd0, q});
        check("R4 status untouched", statusReg, sExp);
      end
    end

    // R3: privileged state holds, then delivery on return to user state
    doReset();
    writeReg(2'd0, 64'h4000);
    writeReg(2'd2, statusVal(1, 1));
    facEn = 1; mmcrEbe = 1; userMode = 0; curNia = 64'h888;
    pmIrq = 1; step(); pmIrq = 0;
    for (int k = 0; k < 5; k++) step();
    check("R3 held in privileged state", {63'd0, pending}, 64'd1);
    check("R3 no redirect while privileged", {63'd0, redirect}, 64'd0);
    userMode = 1; step();
    check("R3 delivered in user state", {63'd0, redirect}, 64'd1);
    check("R3 target after wait", redirectAddr, 64'h4000);

    // R8: writes colliding with a take are dropped
    doReset();
    writeReg(2'd0, 64'h5000);
    writeReg(2'd2, statusVal(1, 1));
    facEn = 1; mmcrEbe = 1; userMode = 1; curNia = 64'h999;
    pmIrq = 1; step(); pmIrq = 0;
    wrEn = 1; wrSel = 2'd2; wrData = 64'd0;
    step();
    wrEn = 0;
    check("R8 take happened", {63'd0, redirect}, 64'd1);
    check("R8 status write dropped", {63'd0, statusReg[32]}, 64'd1);
    rearm = 1; wrEn = 1; wrSel = 2'd0; wrData = 64'h7777_0000;
    step();
    rearm = 0; wrEn = 0;
    check("R8 handler write dropped on rearm", handlerAddr, 64'h5000);

    // R7: rearm blocks a take in the same cycle
    doReset();
    writeReg(2'd0, 64'h6000);
    writeReg(2'd1, 64'h6100);
    writeReg(2'd2, statusVal(1, 1));
    facEn = 1; mmcrEbe = 1; userMode = 1; curNia = 64'hAAA;
    pmIrq = 1; step(); pmIrq = 0;
    rearm = 1; step(); rearm = 0;
    check("R7 rearm wins target", redirectAddr, 64'h6100);
    check("R7 request kept", {63'd0, pending}, 64'd1);
    step();
    check("R7 take follows", redirectAddr, 64'h6000);
    check("R7 take return", returnAddr, 64'hAAA);

    // R5: request arriving on the take edge stays pending
    doReset();
    writeReg(2'd2, statusVal(1, 1));
    facEn = 1; mmcrEbe = 1; userMode = 1;
    pmIrq = 1; step(); step(); pmIrq = 0;
    check("R5 new request on take edge", {63'd0, pending}, 64'd1);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule